// File: doc/BRIEF.md
# Frame-Sync Triggered Parallel Capture Port

This block is a parallel input port that takes in samples of up to 16 bits, clocked by an external port clock. It stays idle until it sees a rising edge on the external frame-sync input. It then waits a programmed number of port clocks and reads a programmed number of consecutive samples. Each captured sample appears on a registered output with a one-cycle valid strobe. A single-cycle done pulse follows the last sample. After that the port goes back to waiting for the next frame sync.

Three settings are taken from the configuration inputs at the moment the frame sync is accepted: the delay, the sample count and the width code. These settings then stay fixed for that capture, so software may change the inputs while a capture is running. The width code gives the sample size in bits. Codes 8 and 10 through 16 are honoured. Any other code gives a full 16-bit sample. Data bits above the selected width are forced to zero.

Top module: `fsync_capture`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `valid_o`, `done_o` and `sample_o` are all zero.
- R2: A capture starts only when `fsync_i` is high at a clock edge after being low at the previous edge. A sync held high does not start another capture.
- R3: With a latched delay of D, the first sample is the data present at the (D+1)-th clock edge after the edge that detected the sync. D = 0 takes the very next edge.
- R4: With a latched count of N (1 to 255), exactly N samples are taken on consecutive edges, and each one raises `valid_o` for the cycle after its edge.
- R5: `done_o` is high for exactly one cycle. That cycle immediately follows the cycle in which the last `valid_o` was high.
- R6: Width code 8 or any code from 10 to 16 delivers the low that-many bits of the data, with all higher bits of `sample_o` zero.
- R7: Width codes 0–7, 9 and 17–31 deliver all 16 data bits.
- R8: Sync edges that arrive while a capture is waiting or sampling are ignored and never start a second capture.
- R9: A count of zero at the sync edge means the edge is ignored: no valid and no done follow.
- R10: Delay, count and width are latched at the accepted sync edge. Later changes to those inputs do not affect the capture in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync_i | input | 1 | External frame sync |
| din_i | input | 16 | Parallel sample data |
| delay_i | input | 8 | Port clocks to wait after the sync before the first read |
| count_i | input | 8 | Number of samples to read per sync |
| width_i | input | 5 | Sample width code in bits |
| sample_o | output | 16 | Captured sample, masked to the selected width |
| valid_o | output | 1 | Sample strobe, one cycle per sample |
| done_o | output | 1 | One-cycle pulse after the final sample |

## Verification
The bench sweeps delays of 0 to 5 and counts of 1 to 5, and also the largest delay and count. It compares every output cycle against a timing model, so a design that is off by one edge in the delay or sample counting shifts or drops a strobe and shows up at once. All 32 width codes are swept. A wrong mask or a wrong fallback for 9 or above-16 codes leaves stray upper bits or clips the sample. Extra runs cover the following cases:
- sync toggling or held high during a capture, which catches a design that retriggers;
- a count of zero, which catches a design that runs a phantom capture;
- configuration inputs changed mid-capture, which catches a design that reads them live instead of latching them.

// File: rtl/fsync_capture.sv
module fsync_capture #(
  parameter int DW     = 16,
  parameter int DLY_W  = 8,
  parameter int CNT_W  = 8,
  parameter int WSEL_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync_i,
  input  logic [DW-1:0]     din_i,
  input  logic [DLY_W-1:0]  delay_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [WSEL_W-1:0] width_i,
  output logic [DW-1:0]     sample_o,
  output logic              valid_o,
  output logic              done_o
);

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_WAIT = 2'd1, S_CAP = 2'd2} st_t;

  st_t              st;
  logic             fs_q;
  logic             fin_q;
  logic [DLY_W-1:0] dly_cnt;
  logic [CNT_W-1:0] left;
  logic [DW-1:0]    mask_q;
  logic             sync_edge;

  assign sync_edge = fsync_i & ~fs_q;

  function automatic logic [DW-1:0] mask_for(logic [WSEL_W-1:0] w);
    int eff;
    logic [DW-1:0] m;
    if (w == WSEL_W'(8))                             eff = 8;
    else if (w >= WSEL_W'(10) && w <= WSEL_W'(16))   eff = int'(w);
    else                                             eff = 16;
    if (eff > DW) eff = DW;
    for (int i = 0; i < DW; i++) m[i] = (i < eff);
    return m;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      fs_q     <= 1'b0;
      fin_q    <= 1'b0;
      dly_cnt  <= '0;
      left     <= '0;
      mask_q   <= '0;
      sample_o <= '0;
      valid_o  <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      fs_q    <= fsync_i;
      valid_o <= 1'b0;
      fin_q   <= 1'b0;
      done_o  <= fin_q;
      case (st)
        S_IDLE: begin
          if (sync_edge && count_i != '0) begin
            mask_q  <= mask_for(width_i);
            left    <= count_i;
            dly_cnt <= delay_i;
            st      <= (delay_i == '0) ? S_CAP : S_WAIT;
          end
        end
        S_WAIT: begin
          dly_cnt <= dly_cnt - 1'b1;
          if (dly_cnt == DLY_W'(1)) st <= S_CAP;
        end
        S_CAP: begin
          sample_o <= din_i & mask_q;
          valid_o  <= 1'b1;
          left     <= left - 1'b1;
          if (left == CNT_W'(1)) begin
            st    <= S_IDLE;
            fin_q <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module fsync_capture_chk #(
  parameter int DW    = 16,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fsync_i,
  input logic             fs_q,
  input logic [CNT_W-1:0] count_i,
  input logic [1:0]       st,
  input logic [DW-1:0]    mask_q,
  input logic [DW-1:0]    sample_o,
  input logic             valid_o,
  input logic             done_o
);

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && fsync_i && !fs_q && count_i != '0) |=> st != 2'd0);

  p_zero_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && count_i == '0) |=> st == 2'd0);

  p_valid_from_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(st) == 2'd2);

  p_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (sample_o & ~mask_q) == '0);

  p_done_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(valid_o) && !valid_o));

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

bind fsync_capture fsync_capture_chk #(.DW(DW), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .fsync_i(fsync_i), .fs_q(fs_q), .count_i(count_i),
  .st(st), .mask_q(mask_q), .sample_o(sample_o), .valid_o(valid_o), .done_o(done_o)
);

// File: tb/fsync_capture_tb.sv
`timescale 1ns/1ps
module fsync_capture_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fsync_i = 1'b0;
  logic [15:0] din_i = '0;
  logic [7:0]  delay_i = '0;
  logic [7:0]  count_i = '0;
  logic [4:0]  width_i = '0;
  logic [15:0] sample_o;
  logic        valid_o;
  logic        done_o;

  int checks = 0;
  int fails  = 0;
  int seed   = 0;
  bit ended  = 0;

  always #2.5 clk = ~clk;

  fsync_capture dut_i (
    .clk(clk), .rst_n(rst_n), .fsync_i(fsync_i), .din_i(din_i),
    .delay_i(delay_i), .count_i(count_i), .width_i(width_i),
    .sample_o(sample_o), .valid_o(valid_o), .done_o(done_o)
  );

  function automatic logic [15:0] pat(int k);
    return 16'((k + seed) * 40503) ^ 16'hA5C3;
  endfunction

  function automatic logic [15:0] emask(int w);
    int eff;
    if (w == 8) eff = 8;
    else if (w >= 10 && w <= 16) eff = w;
    else eff = 16;
    return 16'((17'd1 << eff) - 17'd1);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // mode 0: one pulse, 1: toggle during capture, 2: hold high
  task automatic run(int d, int n, int w, int mode, bit scramble);
    int last;
    string vreq, sreq;
    seed++;
    last = d + n + 4;
    vreq = (n == 0) ? "R9" : (mode != 0 ? "R8/R4" : "R3/R4");
    sreq = (w == 8 || (w >= 10 && w <= 16)) ? "R6" : "R7";
    if (scramble) sreq = "R10";
    @(negedge clk);
    delay_i = 8'(d); count_i = 8'(n); width_i = 5'(w);
    fsync_i = 1'b1; din_i = pat(0);
    for (int j = 1; j <= last; j++) begin
      int k;
      bit ev, ed;
      @(negedge clk);
      k  = j - 1;
      ev = (n > 0) && k >= d + 1 && k <= d + n;
      ed = (n > 0) && k == d + n + 1;
      chk(valid_o == ev, vreq, int'(valid_o), int'(ev));
      chk(done_o == ed, "R5", int'(done_o), int'(ed));
      if (ev && valid_o)
        chk(sample_o == (pat(k) & emask(w)), sreq, int'(sample_o), int'(pat(k) & emask(w)));
      din_i = pat(j);
      if (scramble) begin
        delay_i = 8'(d + 3); count_i = 8'(n + 2); width_i = 5'(w ^ 5'h1B);
      end
      if (mode == 1)      fsync_i = (j <= d + n) ? j[0] : 1'b0;
      else if (mode == 2) fsync_i = (j < last);
      else                fsync_i = 1'b0;
    end
    @(negedge clk);
    chk(valid_o == 1'b0 && done_o == 1'b0, "R2/R8", int'(valid_o), 0);
  endtask

  initial begin
    #1000000;
    if (!ended) begin
      ended = 1;
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(valid_o == 0 && done_o == 0 && sample_o == 0, "R1", int'(sample_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(valid_o == 0 && done_o == 0 && sample_o == 0, "R1", int'(sample_o), 0);
    for (int d = 0; d <= 5; d++)
      for (int n = 1; n <= 5; n++)
        run(d, n, 16, 0, 0);
    for (int w = 0; w < 32; w++) run(w % 3, 2, w, 0, 0);
    run(0, 1, 8, 0, 0);
    run(255, 255, 12, 0, 0);
    run(2, 4, 10, 1, 0);
    run(0, 6, 16, 1, 0);
    run(1, 3, 13, 2, 0);
    run(0, 0, 16, 0, 0);
    run(3, 0, 8, 2, 0);
    run(2, 3, 11, 0, 1);
    run(0, 4, 8, 0, 1);
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule